// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A free-standing supervision timer for a processor subsystem. A down counter is preloaded from one of sixteen power-of-two ranges and is decremented once per clock while the watchdog is armed. Software must keep reloading it by writing a restart key. If it reaches zero, the block reacts in one of two ways. It can request a system reset straight away. Or it can raise an interrupt first and request a reset only if a second expiry arrives while that interrupt is still pending.

The reset request leaves the block as a single pulse whose length software sets, counted in clock cycles. While the pulse is high the counter is frozen. Once the watchdog has been armed, only a hardware reset of the block can disarm it. All control goes through a small synchronous register port with combinational read data.

Register map (3-bit word address): 0 = control (bit 0 arm, write 1 only; bit 1 response mode, 0 = reset, 1 = interrupt first; bits [4 +: RANGE_W] range index). 1 = pulse length L. 2 = restart (write only, key 0x76). 3 = current count (read only). 4 = status (bit 0 interrupt pending). 5 = interrupt clear (a write or a read clears the flag; a read returns the pending bit).

Top module: `wdg_top`

## Requirements
- R1: After reset, irq_o and rst_req_o are 0, the control register reads 0, status reads 0 and the count reads the range-0 preload.
- R2: While unarmed, the counter does not decrement and no expiry occurs; the count follows the preload of the selected range.
- R3: Range index i gives a preload P = 2^(BASE_EXP+i) − 1. A preload loaded at one clock edge decrements by one per cycle, reads 0 P cycles later, and expires at the next edge, which also reloads P.
- R4: A write of exactly 0x76 to the restart register reloads the count with P of the current range. Writes of any other value leave the count decrementing and cause no reset.
- R5: In mode 0 an expiry starts a reset pulse on the following cycle, and irq_o stays 0.
- R6: In mode 1 an expiry with no pending interrupt sets irq_o on the following cycle, reloads the counter and requests no reset.
- R7: In mode 1 an expiry while the interrupt is pending starts a reset pulse. If the interrupt was cleared in between, the next expiry only raises the interrupt again.
- R8: Each expiry that requests a reset produces exactly one pulse on rst_req_o, L+1 cycles long.
- R9: While rst_req_o is high the count holds its value. Decrementing resumes one cycle after the pulse ends.
- R10: A control write with bit 0 clear does not disarm the watchdog; the arm bit still reads 1 and the counter keeps running.
- R11: A write to, or a read of, the interrupt clear register drops irq_o on the next cycle.
- R12: Status bit 0 reflects the pending interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for read-to-clear) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| irq_o | output | 1 | Pending interrupt from the first expiry in mode 1 |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench goes after the expiry instant to the cycle. A counter that is off by one would reach zero, or raise the interrupt, a cycle early or late. It also measures the reset pulse length. A pulse generator that loses the +1, or that retriggers, would show a pulse that is too short or a second pulse.

The interrupt-first mode is tested both with the flag left pending and after it has been cleared by a write and by a read. A design that ignores the pending state would reset too early or never reset at all.

Random restart values other than the key, mixed with random range switches, test the key decode. A loose compare would reload the counter where it must keep decrementing. Writing the arm bit as 0 tests that the watchdog stays armed.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_PLEN  = 3'd1,
      A_KICK  = 3'd2,
      A_COUNT = 3'd3,
      A_STAT  = 3'd4,
      A_ICLR  = 3'd5
   } wdg_addr_e;

   localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_BIT = 1;
   localparam int CTRL_RNG_LSB  = 4;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int RANGE_W  = 4,
   parameter int PLEN_W   = 8,
   parameter logic [PLEN_W-1:0] PLEN_RST = '0,
   parameter bit RD_CLR   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [CNT_W-1:0]    count,
   input  logic                irq_pend,
   output logic [DATA_W-1:0]   rdata,
   output logic                en,
   output logic                mode,
   output logic [RANGE_W-1:0]  range_sel,
   output logic [PLEN_W-1:0]   plen,
   output logic                kick,
   output logic                clr
);

   logic wr_ctrl, wr_plen, wr_kick, wr_iclr, rd_iclr;

   assign wr_ctrl = wr && (addr == A_CTRL);
   assign wr_plen = wr && (addr == A_PLEN);
   assign wr_kick = wr && (addr == A_KICK);
   assign wr_iclr = wr && (addr == A_ICLR);

   generate
      if (RD_CLR) begin : g_rdclr
         assign rd_iclr = rd && (addr == A_ICLR);
      end else begin : g_no_rdclr
         assign rd_iclr = 1'b0;
      end
   endgenerate

   assign kick = wr_kick && (wdata == KICK_KEY);
   assign clr  = wr_iclr || rd_iclr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         mode      <= 1'b0;
         range_sel <= '0;
         plen      <= PLEN_RST;
      end else begin
         if (wr_ctrl) begin
            en        <= en | wdata[CTRL_EN_BIT];
            mode      <= wdata[CTRL_MODE_BIT];
            range_sel <= wdata[CTRL_RNG_LSB +: RANGE_W];
         end
         if (wr_plen) begin
            plen <= wdata[PLEN_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[CTRL_EN_BIT]              = en;
            rdata[CTRL_MODE_BIT]            = mode;
            rdata[CTRL_RNG_LSB +: RANGE_W]  = range_sel;
         end
         A_PLEN:  rdata[PLEN_W-1:0] = plen;
         A_COUNT: rdata[CNT_W-1:0]  = count;
         A_STAT:  rdata[0]          = irq_pend;
         A_ICLR:  rdata[0]          = irq_pend;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CNT_W    = 32,
   parameter int RANGE_W  = 4,
   parameter int BASE_EXP = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [RANGE_W-1:0] range_sel,
   input  logic               kick,
   input  logic               hold,
   output logic [CNT_W-1:0]   count,
   output logic               timeout
);

   localparam int N_RANGE = 2 ** RANGE_W;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] preload_tab [N_RANGE];
   logic [CNT_W-1:0] preload;

   generate
      for (genvar i = 0; i < N_RANGE; i++) begin : g_tab
         assign preload_tab[i] = (ONE << (BASE_EXP + i)) - ONE;
      end
   endgenerate

   assign preload = preload_tab[range_sel];
   assign timeout = en && !hold && !kick && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= preload_tab[0];
      end else if (!en || kick || timeout) begin
         count <= preload;
      end else if (!hold) begin
         count <= count - ONE;
      end
   end

endmodule

// File: rtl/wdg_resp.sv
module wdg_resp (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout,
   input  logic mode,
   input  logic clr,
   output logic irq,
   output logic fire
);

   logic first_hit;

   assign first_hit = timeout && mode && !irq;
   assign fire      = timeout && (!mode || irq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (first_hit) begin
         irq <= 1'b1;
      end else if (clr) begin
         irq <= 1'b0;
      end
   end

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
   parameter int PLEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [PLEN_W-1:0] plen,
   output logic              active
);

   logic [PLEN_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         left_q <= '0;
      end else if (active) begin
         if (left_q == '0) begin
            active <= 1'b0;
         end else begin
            left_q <= left_q - PLEN_W'(1);
         end
      end else if (fire) begin
         active <= 1'b1;
         left_q <= plen;
      end
   end

endmodule

// File: rtl/wdg_top.sv
module wdg_top
   import wdg_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int RANGE_W  = 4,
   parameter int BASE_EXP = 16,
   parameter int PLEN_W   = 8,
   parameter logic [PLEN_W-1:0] PLEN_RST = 8'd15,
   parameter bit RD_CLR   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq_o,
   output logic        rst_req_o
);

   localparam int TOP_EXP = BASE_EXP + (2 ** RANGE_W) - 1;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= DATA_W)
         else $error("wdg_top: CNT_W must lie in 2..%0d", DATA_W);
      assert (TOP_EXP <= CNT_W)
         else $error("wdg_top: largest range needs %0d counter bits", TOP_EXP);
      assert (CTRL_RNG_LSB + RANGE_W <= DATA_W)
         else $error("wdg_top: range field does not fit the data word");
      assert (PLEN_W >= 1 && PLEN_W <= DATA_W)
         else $error("wdg_top: PLEN_W must lie in 1..%0d", DATA_W);
   end

   logic               en_w, mode_w, kick_w, clr_w, tmo_w, fire_w, hold_w;
   logic [RANGE_W-1:0] rng_w;
   logic [PLEN_W-1:0]  plen_w;
   logic [CNT_W-1:0]   cnt_w;

   wdg_regs #(
      .CNT_W    (CNT_W),
      .RANGE_W  (RANGE_W),
      .PLEN_W   (PLEN_W),
      .PLEN_RST (PLEN_RST),
      .RD_CLR   (RD_CLR)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .rd        (reg_rd),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .count     (cnt_w),
      .irq_pend  (irq_o),
      .rdata     (reg_rdata),
      .en        (en_w),
      .mode      (mode_w),
      .range_sel (rng_w),
      .plen      (plen_w),
      .kick      (kick_w),
      .clr       (clr_w)
   );

   wdg_counter #(
      .CNT_W    (CNT_W),
      .RANGE_W  (RANGE_W),
      .BASE_EXP (BASE_EXP)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_w),
      .range_sel (rng_w),
      .kick      (kick_w),
      .hold      (hold_w),
      .count     (cnt_w),
      .timeout   (tmo_w)
   );

   wdg_resp resp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .timeout (tmo_w),
      .mode    (mode_w),
      .clr     (clr_w),
      .irq     (irq_o),
      .fire    (fire_w)
   );

   wdg_pulse #(
      .PLEN_W (PLEN_W)
   ) pulse_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire_w),
      .plen   (plen_w),
      .active (rst_req_o)
   );

   assign hold_w = rst_req_o;

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             mode,
   input logic             timeout,
   input logic             kick,
   input logic             irq,
   input logic             rst_req,
   input logic [CNT_W-1:0] count
);

   // R2
   unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !timeout);

   // R10
   arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en);

   // R5
   direct_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !mode) |=> rst_req);

   // R6
   first_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && mode && !irq) |=> (irq && !rst_req));

   // R7
   second_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && mode && irq) |=> rst_req);

   // R8
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(timeout));

   // R9
   hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !kick) |=> $stable(count));

endmodule

bind wdg_top wdg_chk #(.CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en_w),
   .mode    (mode_w),
   .timeout (tmo_w),
   .kick    (kick_w),
   .irq     (irq_o),
   .rst_req (rst_req_o),
   .count   (cnt_w)
);

// File: tb/wdg_top_tb_top.sv
module wdg_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 4;
   localparam int WD_CYCLES  = 150000;

   localparam logic [2:0] A_CTRL = 3'd0, A_PLEN = 3'd1, A_KICK = 3'd2,
                          A_COUNT = 3'd3, A_STAT = 3'd4, A_ICLR = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, rst_req_o;

   int total = 0;
   int bad   = 0;
   int rst_rises = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge rst_req_o) rst_rises++;

   wdg_top #(.BASE_EXP(BASE)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   function automatic longint preload(input int r);
      return (longint'(1) << (BASE + r)) - 1;
   endfunction

   function automatic logic [31:0] ctrl_word(input bit arm, input bit md, input int r);
      return (32'(r) << 4) | (32'(md) << 1) | 32'(arm);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung actual=%0d expected=0", WD_CYCLES);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c1, c2;
      int r, p, plen_a, plen_b, n, rises0;
      bit irq_seen, rst_seen;

      void'($urandom(32'd20240611));
      r      = $urandom_range(0, 2);
      p      = int'(preload(r));
      plen_a = $urandom_range(0, 7);
      plen_b = $urandom_range(3, 12);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
      chk(rst_req_o == 1'b0, "R1 rst_req", rst_req_o, 0);
      peek(A_CTRL, v);  chk(v == 0, "R1 ctrl", v, 0);
      peek(A_STAT, v);  chk(v == 0, "R1 status", v, 0);
      peek(A_COUNT, v); chk(v == preload(0), "R1 count", v, preload(0));

      // R2: unarmed, range selected, no counting
      wr(A_CTRL, ctrl_word(0, 0, r));
      repeat (3 * p) @(negedge clk);
      peek(A_COUNT, v); chk(v == preload(r), "R2 count frozen", v, preload(r));
      chk(rst_rises == 0, "R2 no reset", rst_rises, 0);
      chk(irq_o == 1'b0, "R2 no irq", irq_o, 0);

      // arm in mode 1, exact expiry timing
      wr(A_PLEN, 32'(plen_a));
      wr(A_CTRL, ctrl_word(1, 1, r));
      peek(A_COUNT, v); chk(v == p, "R3 loaded", v, p);
      repeat (p) @(negedge clk);
      peek(A_COUNT, v); chk(v == 0, "R3 reaches zero", v, 0);
      chk(irq_o == 1'b0, "R3 no early irq", irq_o, 0);
      @(negedge clk);
      chk(irq_o == 1'b1, "R6 first expiry irq", irq_o, 1);
      chk(rst_req_o == 1'b0, "R6 no reset", rst_req_o, 0);
      peek(A_COUNT, v); chk(v == p, "R6 reload", v, p);
      peek(A_STAT, v); chk(v[0] == 1'b1, "R12 status pending", v[0], 1);
      repeat (p + 1) @(negedge clk);
      chk(rst_req_o == 1'b1, "R7 second expiry reset", rst_req_o, 1);
      n = 0;
      while (rst_req_o && n < 300) begin
         n++;
         peek(A_COUNT, v); chk(v == p, "R9 hold in pulse", v, p);
         @(negedge clk);
      end
      chk(n == plen_a + 1, "R8 pulse length", n, plen_a + 1);
      peek(A_COUNT, v); chk(v == p, "R9 hold last", v, p);
      @(negedge clk);
      peek(A_COUNT, v); chk(v == p - 1, "R9 resume", v, p - 1);
      chk(rst_rises == 1, "R8 single pulse", rst_rises, 1);

      // R11 write clear
      wr(A_ICLR, 32'h0);
      chk(irq_o == 1'b0, "R11 write clear", irq_o, 0);
      peek(A_STAT, v); chk(v[0] == 1'b0, "R12 status clear", v[0], 0);

      // R7: cleared interrupt -> next expiry gives irq only
      rises0 = rst_rises; irq_seen = 0;
      for (int k = 0; k < 2 * p + 8 && !irq_seen; k++) begin
         @(negedge clk);
         if (irq_o) irq_seen = 1;
      end
      chk(irq_seen, "R7 irq again", irq_seen, 1);
      chk(rst_rises == rises0, "R7 no reset after clear", rst_rises, rises0);

      // R11 read clear
      rd(A_ICLR, v);
      chk(v[0] == 1'b1, "R11 read returns pending", v[0], 1);
      chk(irq_o == 1'b0, "R11 read clear", irq_o, 0);

      // R10 arm is sticky
      wr(A_CTRL, ctrl_word(0, 0, r));
      peek(A_CTRL, v); chk(v[0] == 1'b1, "R10 arm stays", v[0], 1);
      peek(A_COUNT, c1);
      @(negedge clk);
      peek(A_COUNT, c2); chk(c1 != c2, "R10 still counting", c2, c1);

      // R5 mode 0 direct reset
      wr(A_PLEN, 32'(plen_b));
      rises0 = rst_rises; irq_seen = 0; rst_seen = 0;
      for (int k = 0; k < 2 * p + 8 && !rst_seen; k++) begin
         @(negedge clk);
         if (irq_o) irq_seen = 1;
         if (rst_req_o) rst_seen = 1;
      end
      chk(rst_seen, "R5 reset pulse", rst_seen, 1);
      chk(!irq_seen, "R5 no irq", irq_seen, 0);
      n = 0;
      while (rst_req_o && n < 300) begin
         n++;
         @(negedge clk);
      end
      chk(n == plen_b + 1, "R8 pulse length mode0", n, plen_b + 1);
      chk(rst_rises == rises0 + 1, "R8 one pulse mode0", rst_rises, rises0 + 1);

      // R4 restart key, random ranges and random non-key values
      rises0 = rst_rises;
      for (int it = 0; it < 25; it++) begin
         int r2, pp, w;
         logic [31:0] bogus;
         r2 = $urandom_range(0, 2);
         pp = int'(preload(r2));
         wr(A_CTRL, ctrl_word(1, 0, r2));
         wr(A_KICK, 32'h76);
         peek(A_COUNT, v); chk(v == pp, "R4 key reload", v, pp);
         do bogus = $urandom(); while (bogus == 32'h76);
         if (it % 5 == 0) bogus = 32'h176;
         wr(A_KICK, bogus);
         peek(A_COUNT, v); chk(v == pp - 1, "R4 bad key ignored", v, pp - 1);
         w = $urandom_range(0, pp - 4);
         repeat (w) @(negedge clk);
      end
      chk(rst_rises == rises0, "R4 kept alive", rst_rises, rises0);
      chk(rst_req_o == 1'b0, "R4 no reset active", rst_req_o, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule